// File: doc/BRIEF.md
# Sampled Interrupt Polling Controller

This block decides when a single-clock-per-cycle 8051-style core should take a hardware call into an interrupt service routine, and which routine it should take. It keeps the interrupt flag register itself. Peripherals set flags through single-cycle pulses. Software can overwrite the whole flag vector, and such a write has the same effect as hardware changing those bits. On every clock the block copies the flag register into a sample register. In the next cycle it polls that sample against the per-source enables, the global enable and each source's two-bit priority level.

A call is offered only in a cycle that ends an instruction. It is withheld in three cases: the instruction is a return from interrupt, the instruction writes the enable or priority registers, or a routine of equal or higher level is already in service. A request that is denied leaves no trace. Every poll looks only at what the sample register holds at that moment. Once a request is raised, it holds its vector index until the core acknowledges it. The acknowledge clears the source's flag if that source is configured as hardware-cleared, and it records the source's level as in service. A return from interrupt that completes retires the highest in-service level.

The core, the vector address table and the peripherals that produce the flags sit outside the block.

Top module: `irq_poll_ctrl`

## Requirements
- R1: After reset the flag vector is all zero, `call_req` is low and `isr_active` is low.
- R2: A flag set by a `hw_set` pulse shows on `flags` after the next rising edge. `call_req` rises two further edges later, once the flag has been sampled and then polled, if nothing blocks it.
- R3: No call is raised from a polling cycle in which `instr_last` is low. A flag that is still set is taken on the first polling cycle with `instr_last` high.
- R4: No call is raised from a polling cycle in which `instr_reti` or `instr_wr_ctl` is high. A pending flag is taken in the first clean cycle after such an instruction.
- R5: A source is taken while a routine is in service only if its level is strictly above the highest in-service level. A source at an equal or lower level is held off.
- R6: A denied flag is not remembered. If the flag is cleared before the blocking condition lifts, no call follows.
- R7: An acknowledge (`call_ack` high while `call_req` is high) clears the acknowledged source's flag only when that source's bit in `HW_CLR_MASK` is 1. Otherwise the flag stays set.
- R8: `sw_wr` replaces the entire flag vector with `sw_data` on the next edge. A software write takes precedence over a `hw_set` pulse and over an acknowledge clear in the same cycle.
- R9: A source takes part only when its `src_en` bit and `glb_en` are both 1.
- R10: The level of source i is {`pri_hi[i]`, `pri_lo[i]`}, with 3 as the highest. The highest level wins, and among sources at that level the lowest index wins. `call_vec` gives the winner's index.
- R11: `call_req` stays high with `call_vec` unchanged until it is acknowledged. It drops on the edge that samples the acknowledge.
- R12: An acknowledge makes the request's level in service. A cycle with both `instr_last` and `instr_reti` high retires the highest in-service level. `isr_active` shows whether any level is in service, and `isr_level` shows the highest in-service level (0 when none is in service).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_set | input | NUM_SRC | One-cycle flag set pulses from peripherals |
| sw_wr | input | 1 | Software write strobe for the flag vector |
| sw_data | input | NUM_SRC | Flag value written by software |
| flags | output | NUM_SRC | Current flag register |
| glb_en | input | 1 | Global interrupt enable |
| src_en | input | NUM_SRC | Per-source enables |
| pri_lo | input | NUM_SRC | Low priority bit per source |
| pri_hi | input | NUM_SRC | High priority bit per source |
| instr_last | input | 1 | Current cycle is the final cycle of the instruction |
| instr_reti | input | 1 | Current instruction is a return from interrupt |
| instr_wr_ctl | input | 1 | Current instruction writes enable or priority registers |
| call_req | output | 1 | Hardware call request to the core |
| call_vec | output | IDX_W | Source index of the requested call |
| call_ack | input | 1 | Core accepts the call |
| isr_active | output | 1 | At least one level is in service |
| isr_level | output | 2 | Highest in-service level |

## Verification
The bench builds the block with six sources, the high priority bit in use, and `HW_CLR_MASK` = 6'b001111. With this setting sources 4 and 5 keep their flags through an acknowledge, so the bench can check both clearing behaviours. Six sources with all four levels are enough to produce ties at the top level, masked winners, and two-deep nesting in which a level-1 routine preempts a level-0 routine and is then retired back to it.

// File: rtl/irq_poll_pkg.sv
package irq_poll_pkg;

   localparam int LVL_W   = 2;
   localparam int NUM_LVL = 1 << LVL_W;

   typedef logic [LVL_W-1:0]   lvl_t;
   typedef logic [NUM_LVL-1:0] lvl_map_t;

   // Highest set position of a level bitmap; zero when the map is empty.
   function automatic lvl_t map_top(input lvl_map_t map);
      lvl_t r;
      r = '0;
      for (int i = 0; i < NUM_LVL; i++) begin
         if (map[i]) r = lvl_t'(i);
      end
      return r;
   endfunction

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
   parameter int                  NUM_SRC     = 6,
   parameter logic [NUM_SRC-1:0]  HW_CLR_MASK = '1,
   localparam int                 IDX_W       = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] hw_set,
   input  logic               sw_wr,
   input  logic [NUM_SRC-1:0] sw_data,
   input  logic               clr_en,
   input  logic [IDX_W-1:0]   clr_idx,
   output logic [NUM_SRC-1:0] flag_q,
   output logic [NUM_SRC-1:0] samp_q
);

   logic [NUM_SRC-1:0] clr_vec;
   logic [NUM_SRC-1:0] flag_nxt;

   always_comb begin
      for (int i = 0; i < NUM_SRC; i++) begin
         clr_vec[i] = clr_en && (clr_idx == IDX_W'(i)) && HW_CLR_MASK[i];
      end
   end

   // Software write wins, then peripheral set, then acknowledge clear.
   always_comb begin
      if (sw_wr) flag_nxt = sw_data;
      else       flag_nxt = (flag_q & ~clr_vec) | hw_set;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_q <= '0;
         samp_q <= '0;
      end else begin
         flag_q <= flag_nxt;
         samp_q <= flag_q;
      end
   end

   AST_SW_WRITE_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
      sw_wr |=> (flag_q == $past(sw_data)));                        // R8

   AST_HW_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!sw_wr && (hw_set != '0)) |=> ((flag_q & $past(hw_set)) == $past(hw_set))); // R2

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
   import irq_poll_pkg::*;
#(
   parameter int  NUM_SRC     = 6,
   parameter bit  USE_PRIO_HI = 1'b1,
   localparam int IDX_W       = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic [NUM_SRC-1:0] samp,
   input  logic [NUM_SRC-1:0] src_en,
   input  logic               glb_en,
   input  logic [NUM_SRC-1:0] pri_lo,
   input  logic [NUM_SRC-1:0] pri_hi,
   output logic               any,
   output logic [IDX_W-1:0]   best_idx,
   output lvl_t               best_lvl
);

   lvl_t               src_lvl [NUM_SRC];
   logic [NUM_SRC-1:0] elig;

   assign elig = samp & src_en & {NUM_SRC{glb_en}};

   generate
      if (USE_PRIO_HI) begin : g_four_lvl
         for (genvar i = 0; i < NUM_SRC; i++) begin : g_lvl
            assign src_lvl[i] = {pri_hi[i], pri_lo[i]};
         end
      end else begin : g_two_lvl
         logic unused_hi;
         assign unused_hi = |pri_hi;
         for (genvar i = 0; i < NUM_SRC; i++) begin : g_lvl
            assign src_lvl[i] = {1'b0, pri_lo[i]};
         end
      end
   endgenerate

   // Walk from the top index down; ">=" lets a lower index take a tie.
   always_comb begin
      any      = 1'b0;
      best_idx = '0;
      best_lvl = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (elig[i] && (!any || (src_lvl[i] >= best_lvl))) begin
            any      = 1'b1;
            best_idx = IDX_W'(i);
            best_lvl = src_lvl[i];
         end
      end
   end

endmodule

// File: rtl/irq_level_tracker.sv
module irq_level_tracker
   import irq_poll_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic push,
   input  lvl_t push_lvl,
   input  logic pop,
   output logic active,
   output lvl_t top_lvl
);

   lvl_map_t map_q;
   lvl_map_t map_nxt;

   assign active  = |map_q;
   assign top_lvl = map_top(map_q);

   // Nesting only ever climbs, so a bitmap of levels is a full stack.
   always_comb begin
      map_nxt = map_q;
      if (pop && active) map_nxt[top_lvl] = 1'b0;
      if (push)          map_nxt[push_lvl] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) map_q <= '0;
      else        map_q <= map_nxt;
   end

   AST_PUSH_ABOVE_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      (push && active && !pop) |-> (push_lvl > top_lvl));           // R5

   AST_POP_RETIRES_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && active) |=> (!active || (top_lvl < $past(top_lvl)))); // R12

endmodule

// File: rtl/irq_poll_ctrl.sv
module irq_poll_ctrl
   import irq_poll_pkg::*;
#(
   parameter int                  NUM_SRC     = 6,
   parameter logic [NUM_SRC-1:0]  HW_CLR_MASK = '1,
   parameter bit                  USE_PRIO_HI = 1'b1,
   localparam int                 IDX_W       = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] hw_set,
   input  logic               sw_wr,
   input  logic [NUM_SRC-1:0] sw_data,
   output logic [NUM_SRC-1:0] flags,
   input  logic               glb_en,
   input  logic [NUM_SRC-1:0] src_en,
   input  logic [NUM_SRC-1:0] pri_lo,
   input  logic [NUM_SRC-1:0] pri_hi,
   input  logic               instr_last,
   input  logic               instr_reti,
   input  logic               instr_wr_ctl,
   output logic               call_req,
   output logic [IDX_W-1:0]   call_vec,
   input  logic               call_ack,
   output logic               isr_active,
   output logic [LVL_W-1:0]   isr_level
);

   generate
      if (NUM_SRC < 1 || NUM_SRC > 64) begin : g_bad_src
         $error("irq_poll_ctrl: NUM_SRC must lie in 1..64");
      end
   endgenerate

   logic [NUM_SRC-1:0] samp_q;
   logic               any_elig;
   logic [IDX_W-1:0]   win_idx;
   lvl_t               win_lvl;
   logic               req_q;
   logic [IDX_W-1:0]   vec_q;
   lvl_t               lvl_q;
   logic               ack_fire;
   logic               reti_done;
   logic               blocked;
   logic               issue;
   lvl_t               top_lvl;
   logic               stack_busy;

   irq_flag_bank #(
      .NUM_SRC     (NUM_SRC),
      .HW_CLR_MASK (HW_CLR_MASK)
   ) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .hw_set  (hw_set),
      .sw_wr   (sw_wr),
      .sw_data (sw_data),
      .clr_en  (ack_fire),
      .clr_idx (vec_q),
      .flag_q  (flags),
      .samp_q  (samp_q)
   );

   irq_arbiter #(
      .NUM_SRC     (NUM_SRC),
      .USE_PRIO_HI (USE_PRIO_HI)
   ) u_arb (
      .samp     (samp_q),
      .src_en   (src_en),
      .glb_en   (glb_en),
      .pri_lo   (pri_lo),
      .pri_hi   (pri_hi),
      .any      (any_elig),
      .best_idx (win_idx),
      .best_lvl (win_lvl)
   );

   irq_level_tracker u_lvl (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (ack_fire),
      .push_lvl (lvl_q),
      .pop      (reti_done),
      .active   (stack_busy),
      .top_lvl  (top_lvl)
   );

   assign ack_fire  = call_ack && req_q;
   assign reti_done = instr_last && instr_reti;

   // The three hold-off conditions, plus an already outstanding request.
   assign blocked = req_q || !instr_last || instr_reti || instr_wr_ctl ||
                    (stack_busy && (win_lvl <= top_lvl));
   assign issue   = any_elig && !blocked;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q <= 1'b0;
         vec_q <= '0;
         lvl_q <= '0;
      end else if (issue) begin
         req_q <= 1'b1;
         vec_q <= win_idx;
         lvl_q <= win_lvl;
      end else if (ack_fire) begin
         req_q <= 1'b0;
      end
   end

   assign call_req   = req_q;
   assign call_vec   = vec_q;
   assign isr_active = stack_busy;
   assign isr_level  = top_lvl;

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (call_req && !call_ack) |=> (call_req && $stable(call_vec)));  // R11

   AST_ISSUE_LAST_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(call_req) |-> $past(instr_last));                       // R3

   AST_ISSUE_NOT_RETI_CTL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(call_req) |-> !$past(instr_reti || instr_wr_ctl));      // R4

   AST_ISSUE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(call_req) |-> ($past(glb_en) && (|(($past(src_en) >> call_vec) & NUM_SRC'(1))))); // R9

   AST_ISSUE_FROM_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(call_req) |-> (|(($past(flags, 2) >> call_vec) & NUM_SRC'(1)))); // R6

endmodule

// File: tb/irq_poll_ctrl_bench.sv
module irq_poll_ctrl_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NSRC       = 6;
   localparam logic [NSRC-1:0] CLR_MASK = 6'b001111;

   logic            clk = 1'b0;
   logic            rst_n;
   logic [NSRC-1:0] hw_set, sw_data, flags, src_en, pri_lo, pri_hi;
   logic            sw_wr, glb_en, instr_last, instr_reti, instr_wr_ctl;
   logic            call_req, call_ack, isr_active;
   logic [2:0]      call_vec;
   logic [1:0]      isr_level;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   irq_poll_ctrl #(
      .NUM_SRC     (NSRC),
      .HW_CLR_MASK (CLR_MASK),
      .USE_PRIO_HI (1'b1)
   ) u_irq_poll_ctrl (
      .clk (clk), .rst_n (rst_n), .hw_set (hw_set), .sw_wr (sw_wr),
      .sw_data (sw_data), .flags (flags), .glb_en (glb_en), .src_en (src_en),
      .pri_lo (pri_lo), .pri_hi (pri_hi), .instr_last (instr_last),
      .instr_reti (instr_reti), .instr_wr_ctl (instr_wr_ctl),
      .call_req (call_req), .call_vec (call_vec), .call_ack (call_ack),
      .isr_active (isr_active), .isr_level (isr_level)
   );

   // {flags, src_en, pri_hi, pri_lo, expected vector}
   localparam logic [26:0] TBL [0:7] = '{
      {6'b000001, 6'h3F,     6'b000000, 6'b000000, 3'd0},
      {6'b110000, 6'h3F,     6'b000000, 6'b000000, 3'd4},
      {6'b100100, 6'h3F,     6'b000000, 6'b100000, 3'd5},
      {6'b101010, 6'h3F,     6'b001000, 6'b100000, 3'd3},
      {6'b111111, 6'b011111, 6'b100000, 6'b000000, 3'd0},
      {6'b000110, 6'h3F,     6'b000110, 6'b000110, 3'd1},
      {6'b010100, 6'h3F,     6'b010000, 6'b000100, 3'd4},
      {6'b001001, 6'b001000, 6'b000000, 6'b000000, 3'd3}
   };

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      hw_set = '0; sw_wr = 1'b0; sw_data = '0; glb_en = 1'b1; src_en = '1;
      pri_lo = '0; pri_hi = '0; instr_last = 1'b1; instr_reti = 1'b0;
      instr_wr_ctl = 1'b0; call_ack = 1'b0;
      tick();
      tick();
      rst_n = 1'b1;
   endtask

   task automatic sw_write(input logic [NSRC-1:0] v);
      sw_wr = 1'b1; sw_data = v;
      tick();
      sw_wr = 1'b0;
   endtask

   task automatic ack();
      call_ack = 1'b1;
      tick();
      call_ack = 1'b0;
   endtask

   initial begin
      @(negedge clk);
      do_reset();
      // R1: reset state
      chk("R1 flags", flags, 0);
      chk("R1 call_req", call_req, 0);
      chk("R1 isr_active", isr_active, 0);

      // R10 / R9: arbitration table
      for (int r = 0; r < 8; r++) begin
         do_reset();
         src_en = TBL[r][20:15];
         pri_hi = TBL[r][14:9];
         pri_lo = TBL[r][8:3];
         sw_write(TBL[r][26:21]);
         tick();
         chk("R2 no call before poll", call_req, 0);
         tick();
         chk("R10 call raised", call_req, 1);
         chk("R10 winner index", call_vec, TBL[r][2:0]);
      end

      // R2: peripheral set path latency
      do_reset();
      hw_set = 6'b001000;
      tick();
      hw_set = '0;
      chk("R2 flag visible", flags, 6'b001000);
      chk("R2 not yet", call_req, 0);
      tick();
      chk("R2 sampled only", call_req, 0);
      tick();
      chk("R2 call after poll", call_req, 1);
      chk("R2 vector", call_vec, 3);

      // R3, R11, R7, R12, R5, R4: nesting sequence
      do_reset();
      instr_last = 1'b0;
      sw_write(6'b000001);
      tick(); tick(); tick();
      chk("R3 mid-instruction held", call_req, 0);
      instr_last = 1'b1;
      tick();
      chk("R3 taken at boundary", call_req, 1);
      tick(); tick(); tick();
      chk("R11 request held", call_req, 1);
      chk("R11 vector held", call_vec, 0);
      ack();
      chk("R11 dropped on ack", call_req, 0);
      chk("R12 active after ack", isr_active, 1);
      chk("R12 level after ack", isr_level, 0);
      chk("R7 cleared source", flags, 0);
      pri_lo = 6'b000100;
      sw_write(6'b000110);
      tick(); tick();
      chk("R5 preempt raised", call_req, 1);
      chk("R5 preempt vector", call_vec, 2);
      ack();
      chk("R12 nested level", isr_level, 1);
      chk("R7 flag2 cleared, flag1 kept", flags, 6'b000010);
      instr_reti = 1'b1;
      tick();
      instr_reti = 1'b0;
      chk("R12 pop to level 0", isr_level, 0);
      chk("R12 still active", isr_active, 1);
      tick(); tick();
      chk("R5 equal level held off", call_req, 0);
      instr_reti = 1'b1;
      tick();
      instr_reti = 1'b0;
      chk("R12 empty after pop", isr_active, 0);
      chk("R4 none during RETI", call_req, 0);
      tick();
      chk("R4 taken after RETI", call_req, 1);
      chk("R4 vector after RETI", call_vec, 1);

      // R4: control write blocks
      do_reset();
      instr_wr_ctl = 1'b1;
      sw_write(6'b000001);
      tick(); tick(); tick();
      chk("R4 ctl write held", call_req, 0);
      instr_wr_ctl = 1'b0;
      tick();
      chk("R4 taken after ctl write", call_req, 1);

      // R6 / R8: denied flag is forgotten
      do_reset();
      instr_last = 1'b0;
      hw_set = 6'b000001;
      tick();
      hw_set = '0;
      chk("R2 flag set by pulse", flags, 1);
      tick(); tick();
      sw_write(6'b000000);
      chk("R8 software cancel", flags, 0);
      tick();
      instr_last = 1'b1;
      tick(); tick();
      chk("R6 no memory of denial", call_req, 0);

      // R7: software-cleared source keeps its flag
      do_reset();
      sw_write(6'b010000);
      tick(); tick();
      chk("R7 source 4 called", call_vec, 4);
      ack();
      chk("R7 flag kept", flags, 6'b010000);

      // R9: global enable
      do_reset();
      glb_en = 1'b0;
      sw_write(6'b000001);
      tick(); tick(); tick();
      chk("R9 global off", call_req, 0);
      glb_en = 1'b1;
      tick();
      chk("R9 global on", call_req, 1);

      // R8: write precedence over peripheral set
      do_reset();
      hw_set = 6'b000010;
      sw_wr = 1'b1; sw_data = 6'b000100;
      tick();
      sw_wr = 1'b0; hw_set = '0;
      chk("R8 write wins", flags, 6'b000100);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule